// File: doc/BRIEF.md
# Serial Command Front End for a 16-bit Voltage DAC

This block is the digital control front end of a single-channel 16-bit voltage-output converter. A host sends 24-bit commands over a three-wire serial link made of an active-low frame select, a serial clock and a data line. Data is taken on falling clock edges, most significant bit first.

The three link inputs are synchronised into a system clock that runs at least four times the serial clock rate. A state machine frames the bits and holds the command for the register stage. The register stage keeps the DAC code, a reset-code register and the output mode. Its outputs drive the analog ladder and the output switches. Those analog parts lie outside this block.

Frame layout (bit 23 is sent first):

| Bits | Meaning |
|---|---|
| 15:0 | converter code |
| 21:20 | output mode: 00 normal, 01 three-state, 10 100 kΩ to ground, 11 1 kΩ to ground |
| 22 | reset-code load flag |
| 23, 19:16 | ignored in ordinary frames |

A frame of all ones is a software reset.

A frame select that rises before the 24th edge discards the frame. The one exception is a software reset that has already started.

The state machine has four states:

- **HOLD**: waits for frame select to be high. This is the state after reset and after each completed frame.
- **IDLE**: armed and waiting. The *start* transition to SHIFT happens when frame select is low.
- **SHIFT**: shifts in one bit on each falling serial clock edge. It leaves by one of three transitions:
  - *abort* to IDLE, when frame select rises early;
  - *complete* to HOLD, on the 24th edge;
  - *prefix* to SWR, when the first eight bits are all ones.
- **SWR**: a software reset is in progress. It leaves by *complete* to HOLD on the 24th edge, or by *forced reset* to IDLE when frame select rises early. The forced reset still performs the software reset.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset the DAC code equals the power-on code (zero by default), the mode is 00, the power-down indicator is low, and no update strobe occurs until a command executes.
- R2: On the 24th falling serial clock edge of an ordinary frame with flag bit 22 clear and mode bits 21:20 equal to 00, bits 15:0 become the DAC code. That update is marked by exactly one update strobe pulse.
- R3: Every completed ordinary frame copies bits 21:20 to the mode output. The power-down indicator is high exactly when the mode is not 00.
- R4: A completed frame whose mode bits are not 00 leaves the DAC code unchanged and produces no strobe.
- R5: A frame select rise before the 24th falling edge leaves the code, the mode and the reset-code register untouched and produces no strobe. This holds unless R9 applies.
- R6: Serial clock edges after the 24th, while frame select stays low, are ignored. A new frame needs frame select to go high and then low again.
- R7: A completed ordinary frame with bit 22 set stores bits 15:0 into the reset-code register and leaves the DAC code unchanged with no strobe. Its mode bits still apply. The reset-code register starts at the power-on code.
- R8: A completed all-ones frame loads the reset-code register value into the DAC code, forces mode 00 and gives one strobe.
- R9: Once the first eight bits of a frame are all ones, an early frame select rise still performs the software reset of R8. With fewer than eight ones received, the abort of R5 applies.
- R10: Bits 23 and 19:16 have no effect on an ordinary frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, at least 4x the serial clock rate |
| rst_n | input | 1 | asynchronous active-low reset (power-on) |
| sclk_i | input | 1 | serial clock; data taken on its falling edge |
| fsel_n_i | input | 1 | active-low frame select |
| sdin_i | input | 1 | serial data, MSB first |
| dac_code_o | output | 16 | code driven to the converter core |
| dac_load_o | output | 1 | one-cycle strobe when dac_code_o is written |
| out_mode_o | output | 2 | output mode: 00 normal, 01 three-state, 10 100 kΩ, 11 1 kΩ |
| pwr_down_o | output | 1 | high when out_mode_o is not 00 |

## Verification
Ordinary frames are swept over all four modes. The codes are walking ones mixed with a per-mode pattern, so a swapped or shifted bit shows up at once. Odd frames set the ignored bits 23 and 19:16, which separates decoding of the real fields from decoding of the whole word.

Early aborts are tried at every bit count from 1 to 23. Aborts after an all-ones prefix of exactly eight bits, and of fewer than eight, separate the committed software reset from a plain discard. Frames that run on well past 24 edges with ones on the data line would turn into a spurious software reset if a second frame were accepted without a fresh frame select edge.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int FRAME_W  = 24;
    localparam int CODE_W   = 16;
    localparam int FLAG_BIT = 22;
    localparam int MODE_LSB = 20;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FS_HOLD  = 2'd0,
        FS_IDLE  = 2'd1,
        FS_SHIFT = 2'd2,
        FS_SWR   = 2'd3
    } fsm_state_t;

    typedef enum logic [1:0] {
        OM_NORMAL = 2'b00,
        OM_HIZ    = 2'b01,
        OM_PD100K = 2'b10,
        OM_PD1K   = 2'b11
    } out_mode_t;

    typedef struct packed {
        logic              rst_flag;
        out_mode_t         mode;
        logic [CODE_W-1:0] code;
    } cmd_t;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int             STAGES  = 2,
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_ctrl_pkg::*;
#(
    parameter int SWR_PREFIX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsel_lvl_i,
    input  logic             sclk_lvl_i,
    input  logic             sdin_lvl_i,
    output logic             exec_o,
    output logic             swr_o,
    output cmd_t             cmd_o,
    output logic [CNT_W-1:0] bit_cnt_o
);

    fsm_state_t         state_q, state_d;
    logic [FRAME_W-1:0] shreg_q, shreg_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_prev_q;
    logic               exec_q, swr_q;
    logic               in_frame, sclk_fall, shift_now, last_bit, prefix_hit;

    assign in_frame   = (state_q == FS_SHIFT) || (state_q == FS_SWR);
    assign sclk_fall  = sclk_prev_q && !sclk_lvl_i;
    assign shift_now  = in_frame && !fsel_lvl_i && sclk_fall;
    assign shreg_nx   = {shreg_q[FRAME_W-2:0], sdin_lvl_i};
    assign last_bit   = shift_now && (cnt_q == CNT_W'(FRAME_W - 1));
    assign prefix_hit = shift_now && (state_q == FS_SHIFT)
                     && (cnt_q == CNT_W'(SWR_PREFIX - 1))
                     && (&shreg_nx[SWR_PREFIX-1:0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_HOLD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_HOLD:  if (fsel_lvl_i) state_d = FS_IDLE;
            FS_IDLE:  if (!fsel_lvl_i) state_d = FS_SHIFT;
            FS_SHIFT: begin
                if (fsel_lvl_i)      state_d = FS_IDLE;
                else if (last_bit)   state_d = FS_HOLD;
                else if (prefix_hit) state_d = FS_SWR;
            end
            FS_SWR: begin
                if (fsel_lvl_i)      state_d = FS_IDLE;
                else if (last_bit)   state_d = FS_HOLD;
            end
            default: state_d = FS_HOLD;
        endcase
    end

    // outputs and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            cnt_q       <= '0;
            sclk_prev_q <= 1'b0;
            exec_q      <= 1'b0;
            swr_q       <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_lvl_i;
            exec_q      <= 1'b0;
            swr_q       <= 1'b0;
            unique case (state_q)
                FS_HOLD: ;
                FS_IDLE: begin
                    shreg_q <= '0;
                    cnt_q   <= '0;
                end
                FS_SHIFT, FS_SWR: begin
                    if (fsel_lvl_i) begin
                        shreg_q <= '0;
                        cnt_q   <= '0;
                        if (state_q == FS_SWR) begin
                            exec_q <= 1'b1;
                            swr_q  <= 1'b1;
                        end
                    end else if (shift_now) begin
                        shreg_q <= shreg_nx;
                        cnt_q   <= cnt_q + 1'b1;
                        if (last_bit) begin
                            exec_q <= 1'b1;
                            swr_q  <= &shreg_nx;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign exec_o         = exec_q;
    assign swr_o          = swr_q;
    assign cmd_o.rst_flag = shreg_q[FLAG_BIT];
    assign cmd_o.mode     = out_mode_t'(shreg_q[MODE_LSB +: 2]);
    assign cmd_o.code     = shreg_q[CODE_W-1:0];
    assign bit_cnt_o      = cnt_q;

endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
    import dac_ctrl_pkg::*;
#(
    parameter logic [CODE_W-1:0] POR_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic              swr_i,
    input  cmd_t              cmd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              load_o,
    output out_mode_t         mode_o,
    output logic              pd_o
);

    logic [CODE_W-1:0] code_q, rst_code_q;
    logic              load_q, pd_q;
    out_mode_t         mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= POR_CODE;
            rst_code_q <= POR_CODE;
            mode_q     <= OM_NORMAL;
            pd_q       <= 1'b0;
            load_q     <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (exec_i) begin
                if (swr_i) begin
                    code_q <= rst_code_q;
                    mode_q <= OM_NORMAL;
                    pd_q   <= 1'b0;
                    load_q <= 1'b1;
                end else begin
                    mode_q <= cmd_i.mode;
                    pd_q   <= (cmd_i.mode != OM_NORMAL);
                    if (cmd_i.rst_flag) begin
                        rst_code_q <= cmd_i.code;
                    end else if (cmd_i.mode == OM_NORMAL) begin
                        code_q <= cmd_i.code;
                        load_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign code_o = code_q;
    assign load_o = load_q;
    assign mode_o = mode_q;
    assign pd_o   = pd_q;

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter bit POR_MIDSCALE = 1'b0,
    parameter int SWR_PREFIX   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fsel_n_i,
    input  logic              sdin_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              dac_load_o,
    output logic [1:0]        out_mode_o,
    output logic              pwr_down_o
);

    localparam logic [CODE_W-1:0] POR_CODE =
        POR_MIDSCALE ? (CODE_W'(1) << (CODE_W - 1)) : '0;

    logic [2:0]       link_sync;
    logic             cmd_exec, cmd_swr;
    cmd_t             cmd_word;
    logic [CNT_W-1:0] bit_cnt;
    out_mode_t        mode_w;

    // bit 2: frame select (idles high), bit 1: serial clock, bit 0: data
    dac_in_sync #(
        .STAGES  (SYNC_STAGES),
        .N       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fsel_n_i, sclk_i, sdin_i}),
        .sync_o  (link_sync)
    );

    dac_frame_fsm #(
        .SWR_PREFIX (SWR_PREFIX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsel_lvl_i (link_sync[2]),
        .sclk_lvl_i (link_sync[1]),
        .sdin_lvl_i (link_sync[0]),
        .exec_o     (cmd_exec),
        .swr_o      (cmd_swr),
        .cmd_o      (cmd_word),
        .bit_cnt_o  (bit_cnt)
    );

    dac_cmd_regs #(
        .POR_CODE (POR_CODE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec_i (cmd_exec),
        .swr_i  (cmd_swr),
        .cmd_i  (cmd_word),
        .code_o (dac_code_o),
        .load_o (dac_load_o),
        .mode_o (mode_w),
        .pd_o   (pwr_down_o)
    );

    assign out_mode_o = mode_w;

endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk
    import dac_ctrl_pkg::*;
#(
    parameter logic [CODE_W-1:0] POR_CODE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              dac_load_o,
    input logic [1:0]        out_mode_o,
    input logic              cmd_exec,
    input logic [CNT_W-1:0]  bit_cnt
);

    // R1
    por_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code_o == POR_CODE && out_mode_o == 2'b00 && !dac_load_o));

    // R2
    code_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code_o) |-> dac_load_o);

    // R4
    load_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load_o |-> (out_mode_o == 2'b00));

    // R5
    mode_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_mode_o) |-> $past(cmd_exec));

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk #(
    .POR_CODE (POR_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_code_o (dac_code_o),
    .dac_load_o (dac_load_o),
    .out_mode_o (out_mode_o),
    .cmd_exec   (cmd_exec),
    .bit_cnt    (bit_cnt)
);

// File: tb/dac_serial_ctrl_bench.sv
module dac_serial_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        fsel_n = 1'b1;
    logic        sdin = 1'b0;
    logic [15:0] dac_code;
    logic        dac_load;
    logic [1:0]  out_mode;
    logic        pwr_down;

    int checks = 0;
    int failures = 0;
    int loads_seen = 0;

    logic [15:0] exp_code = 16'h0000;
    logic [15:0] exp_rst  = 16'h0000;
    logic [1:0]  exp_mode = 2'b00;
    int          exp_loads = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_serial_ctrl u_dac_serial_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .fsel_n_i   (fsel_n),
        .sdin_i     (sdin),
        .dac_code_o (dac_code),
        .dac_load_o (dac_load),
        .out_mode_o (out_mode),
        .pwr_down_o (pwr_down)
    );

    always @(negedge clk) if (rst_n && dac_load) loads_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " code"}, 32'(dac_code), 32'(exp_code));
        check({req, " mode"}, 32'(out_mode), 32'(exp_mode));
        check({req, " pd"}, 32'(pwr_down), 32'(exp_mode != 2'b00));
        check({req, " strobes"}, 32'(loads_seen), 32'(exp_loads));
    endtask

    // expected effect of a frame of which nbits bits were clocked in
    task automatic model(input logic [23:0] w, input int nbits);
        if (nbits >= 24) begin
            if (w == 24'hFFFFFF) begin
                exp_code = exp_rst; exp_mode = 2'b00; exp_loads++;
            end else begin
                exp_mode = w[21:20];
                if (w[22]) exp_rst = w[15:0];
                else if (w[21:20] == 2'b00) begin
                    exp_code = w[15:0]; exp_loads++;
                end
            end
        end else if (nbits >= 8 && w[23:16] == 8'hFF) begin
            exp_code = exp_rst; exp_mode = 2'b00; exp_loads++;
        end
    endtask

    // extra bits past 24 carry ones
    task automatic send(input logic [23:0] w, input int nbits);
        @(negedge clk) fsel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 24) ? w[23 - i] : 1'b1;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        fsel_n = 1'b1;
        repeat (10) @(negedge clk);
        model(w, nbits);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [15:0] c;
        logic [23:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check_all("R1");

        // R2 R3 R4 R10 sweep over modes and codes
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 17; k++) begin
                c = (k < 16) ? ((16'h1 << k) ^ (16'(m) * 16'h1111)) : 16'hFFFF - 16'(m);
                w = {1'(k), 1'b0, 2'(m), 4'(k), c};
                send(w, 24);
                check_all(m == 0 ? "R2/R10" : "R3/R4/R10");
            end
        end

        // R2 leave power-down with a normal frame
        send({8'h00, 16'hA5C3}, 24);
        check_all("R2");

        // R5 abort at every bit count
        for (int n = 1; n < 24; n++) begin
            send({8'h50, 16'h1BAD}, n);
            check_all("R5");
        end

        // R7 reset-code load leaves the code, applies the mode
        send({8'h60, 16'h1234}, 24);
        check_all("R7");
        // R8 all-ones frame restores the reset code
        send(24'hFFFFFF, 24);
        check_all("R8");
        check("R8 code", 32'(dac_code), 32'h1234);

        // R6 extra edges with ones after a frame must not start a reset frame
        send({8'h00, 16'h4321}, 48);
        check_all("R6");
        check("R6 code", 32'(dac_code), 32'h4321);

        // R9 prefix of eight ones then abort: forced reset
        send({8'h20, 16'h7777}, 24);
        check_all("R9 setup");
        send(24'hFF0000, 12);
        check_all("R9");
        check("R9 code", 32'(dac_code), 32'h1234);
        // R9 fewer than eight ones then abort: no effect
        send({8'h30, 16'h0F0F}, 24);
        send(24'hFFFFFF, 7);
        check_all("R9 short");
        check("R9 short mode", 32'(out_mode), 32'h3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule